// File: doc/BRIEF.md
# Three-wire serial EEPROM command master

This block runs single-word commands on a three-wire serial EEPROM. It has four pins to the device: chip select, serial clock, serial data toward the device, and serial data from the device. A host starts one command with a one-cycle request. The block accepts the request only when it is idle, and it latches the command, the word address, the write word and the address-width select when it accepts.

Four commands are supported: read one 16-bit word, write one 16-bit word, enable programming and disable programming. Every serial clock level is timed by a system-clock divider, so the serial clock never runs faster than the device allows. After a write, the block waits until the device reports ready, or until a time limit runs out.

The serial clock pin is shared with another function on the board. The block raises an ownership flag for the whole transaction. When the flag falls, the other function may take the pin back. A one-cycle done pulse marks the end of every command, and a read presents its word on the same cycle as that pulse.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, cs_o, sk_o, di_o, own_o, done_o and ack_o are all low.
- R2: A request (req_i high) while own_o is low is acknowledged by ack_o in the same cycle and latches op_i, addr_i, wdata_i and wide_addr_i. own_o is high from the next cycle until the done cycle. A request made while own_o is high gets no ack_o and has no effect.
- R3: A command begins with cs_o rising while sk_o and di_o are low. sk_o then stays low for at least one full phase before its first rising edge.
- R4: Every sk_o level lasts at least PHASE_DIV system cycles.
- R5: Every field is sent most significant bit first. di_o changes only while sk_o is low and is held stable while sk_o is high.
- R6: A read (op_i = 0) sends opcode 110, then the address, then gives 16 rising edges on sk_o. do_i is sampled at the end of each high phase, so the frame has 3+aw+16 rising edges. rdata_o holds the assembled word, first bit in bit 15.
- R7: A write (op_i = 1) sends opcode 101, then the address, then wdata_i, for 3+aw+16 rising edges in total.
- R8: Programming enable (op_i = 2) sends 10011 and programming disable (op_i = 3) sends 10000. Each is followed by six zero bits, for 11 rising edges.
- R9: The address width aw is 8 when wide_addr_i = 1 and 6 when wide_addr_i = 0. With aw = 6, only addr_i[5:0] is sent.
- R10: sk_o is low in the cycle before cs_o falls. cs_o stays low for at least PHASE_DIV cycles before it rises again.
- R11: After a write frame, cs_o goes low for one phase and then high again. The block then watches do_i and ends the wait when do_i is high, or after WR_TIMEOUT cycles. cs_o then goes low for one more phase.
- R12: done_o pulses for exactly one cycle per accepted command, with cs_o and own_o low. It comes after the final low phase of chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Command request |
| op_i | input | 2 | Command: 0 read, 1 write, 2 enable, 3 disable |
| addr_i | input | ADDR_WIDE | Word address |
| wdata_i | input | DATA_W | Word to write |
| wide_addr_i | input | 1 | 1 selects 8 address bits, 0 selects 6 |
| ack_o | output | 1 | Request accepted this cycle |
| rdata_o | output | DATA_W | Last word read |
| done_o | output | 1 | Command finished pulse |
| own_o | output | 1 | Shared clock pin held by this block |
| cs_o | output | 1 | Device chip select |
| sk_o | output | 1 | Device serial clock |
| di_o | output | 1 | Serial data toward the device |
| do_i | input | 1 | Serial data from the device |

## Verification
A wrong bit counter or frame register shows up within one frame: the device model sees the wrong number of clock edges, or decodes the wrong address or data. A later read of that word then returns the wrong value. A wrong phase counter shortens a serial clock level, and the level-width watch catches this at the next edge. A wrong state sequence after a write shows up in the time from request to done: a wait that ends too early or runs too long becomes visible when that single command completes. If a busy request is wrongly accepted, it gives an extra done pulse or a changed stored word within the same transaction.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    MW_READ  = 2'd0,
    MW_WRITE = 2'd1,
    MW_WREN  = 2'd2,
    MW_WRDIS = 2'd3
  } mw_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_LO, S_HI, S_TAIL, S_GAP, S_POLL, S_DONE
  } mw_state_e;

  localparam logic [2:0] OPC_RD  = 3'b110;
  localparam logic [2:0] OPC_WR  = 3'b101;
  localparam logic [4:0] OPC_EN  = 5'b10011;
  localparam logic [4:0] OPC_DIS = 5'b10000;
  localparam int unsigned EXT_PAD = 6;
  localparam int unsigned EXT_W   = 5 + EXT_PAD;
endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
  parameter int unsigned DIV = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mw_frame_fmt.sv
module mw_frame_fmt
  import mw_pkg::*;
#(
  parameter int unsigned ADDR_WIDE   = 8,
  parameter int unsigned ADDR_NARROW = 6,
  parameter int unsigned DATA_W      = 16,
  localparam int unsigned FRAME_W    = 3 + ADDR_WIDE + DATA_W,
  localparam int unsigned CW         = $clog2(FRAME_W + 1)
) (
  input  mw_op_e               op_i,
  input  logic [ADDR_WIDE-1:0] addr_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic                 wide_i,
  output logic [FRAME_W-1:0]   frame_o,
  output logic [CW-1:0]        bits_o
);
  localparam int unsigned DIFF = ADDR_WIDE - ADDR_NARROW;

  logic [2:0]        opc;
  logic [DATA_W-1:0] data_f;
  logic [4:0]        ext_opc;

  always_comb begin
    opc     = (op_i == MW_READ) ? OPC_RD : OPC_WR;
    data_f  = (op_i == MW_WRITE) ? data_i : '0;
    ext_opc = (op_i == MW_WREN) ? OPC_EN : OPC_DIS;
    if (op_i == MW_WREN || op_i == MW_WRDIS) begin
      frame_o = FRAME_W'({ext_opc, {EXT_PAD{1'b0}}}) << (FRAME_W - EXT_W);
      bits_o  = CW'(EXT_W);
    end else if (wide_i) begin
      frame_o = {opc, addr_i, data_f};
      bits_o  = (op_i == MW_READ) ? CW'(3 + ADDR_WIDE) : CW'(3 + ADDR_WIDE + DATA_W);
    end else begin
      // left-align the shorter frame so the engine always shifts from the MSB
      frame_o = FRAME_W'({opc, addr_i[ADDR_NARROW-1:0], data_f}) << DIFF;
      bits_o  = (op_i == MW_READ) ? CW'(3 + ADDR_NARROW) : CW'(3 + ADDR_NARROW + DATA_W);
    end
  end
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_pkg::*;
#(
  parameter int unsigned PHASE_DIV   = 250,
  parameter int unsigned WR_TIMEOUT  = 2500000,
  parameter int unsigned ADDR_WIDE   = 8,
  parameter int unsigned ADDR_NARROW = 6,
  parameter int unsigned DATA_W      = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [1:0]           op_i,
  input  logic [ADDR_WIDE-1:0] addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 wide_addr_i,
  output logic                 ack_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 done_o,
  output logic                 own_o,
  output logic                 cs_o,
  output logic                 sk_o,
  output logic                 di_o,
  input  logic                 do_i
);
  localparam int unsigned FRAME_W = 3 + ADDR_WIDE + DATA_W;
  localparam int unsigned CW      = $clog2(FRAME_W + 1);
  localparam int unsigned TW      = $clog2(WR_TIMEOUT + 1);

  mw_state_e            state_q;
  mw_op_e               op_q;
  logic [FRAME_W-1:0]   frame_q, frame_d;
  logic [CW-1:0]        bits_q, bits_d;
  logic                 rx_q, polled_q, tick, tick_en;
  logic [TW-1:0]        to_q;
  logic [DATA_W-1:0]    rdata_q;

  mw_frame_fmt #(
    .ADDR_WIDE(ADDR_WIDE), .ADDR_NARROW(ADDR_NARROW), .DATA_W(DATA_W)
  ) i_fmt (
    .op_i   (mw_op_e'(op_i)),
    .addr_i (addr_i),
    .data_i (wdata_i),
    .wide_i (wide_addr_i),
    .frame_o(frame_d),
    .bits_o (bits_d)
  );

  assign tick_en = state_q inside {S_SETUP, S_LO, S_HI, S_TAIL, S_GAP};

  mw_tick_gen #(.DIV(PHASE_DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tick_en),
    .tick_o(tick)
  );

  assign ack_o = req_i && (state_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      op_q     <= MW_READ;
      frame_q  <= '0;
      bits_q   <= '0;
      rx_q     <= 1'b0;
      polled_q <= 1'b0;
      to_q     <= '0;
      rdata_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (ack_o) begin
          op_q     <= mw_op_e'(op_i);
          frame_q  <= frame_d;
          bits_q   <= bits_d;
          rx_q     <= 1'b0;
          polled_q <= 1'b0;
          state_q  <= S_SETUP;
        end
        S_SETUP: if (tick) state_q <= S_LO;
        S_LO:    if (tick) state_q <= S_HI;
        S_HI: if (tick) begin
          if (rx_q) rdata_q <= {rdata_q[DATA_W-2:0], do_i};
          if (bits_q == CW'(1)) begin
            if (!rx_q && op_q == MW_READ) begin
              rx_q    <= 1'b1;
              bits_q  <= CW'(DATA_W);
              state_q <= S_LO;
            end else begin
              state_q <= S_TAIL;
            end
          end else begin
            bits_q  <= bits_q - 1'b1;
            frame_q <= frame_q << 1;
            state_q <= S_LO;
          end
        end
        S_TAIL: if (tick) state_q <= S_GAP;
        S_GAP: if (tick) begin
          if (op_q == MW_WRITE && !polled_q) begin
            polled_q <= 1'b1;
            to_q     <= '0;
            state_q  <= S_POLL;
          end else begin
            state_q  <= S_DONE;
          end
        end
        S_POLL: begin
          if (do_i || to_q == TW'(WR_TIMEOUT - 1)) state_q <= S_GAP;
          else                                      to_q    <= to_q + 1'b1;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cs_o    = state_q inside {S_SETUP, S_LO, S_HI, S_TAIL, S_POLL};
  assign sk_o    = (state_q == S_HI);
  assign di_o    = (state_q inside {S_LO, S_HI}) && !rx_q && frame_q[FRAME_W-1];
  assign own_o   = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done_o  = (state_q == S_DONE);
  assign rdata_o = rdata_q;
endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
module mw_eeprom_ctrl_chk #(
  parameter int unsigned PHASE_DIV = 250
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ack_o,
  input logic done_o,
  input logic own_o,
  input logic cs_o,
  input logic sk_o,
  input logic di_o
);
  localparam int unsigned RW = $clog2(PHASE_DIV + 1) + 1;

  logic          sk_q, cs_q;
  logic [RW-1:0] sk_run, cs_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sk_q   <= 1'b0;
      cs_q   <= 1'b0;
      sk_run <= RW'(PHASE_DIV);
      cs_run <= RW'(PHASE_DIV);
    end else begin
      sk_q <= sk_o;
      cs_q <= cs_o;
      if (sk_o != sk_q)                 sk_run <= RW'(1);
      else if (sk_run < RW'(PHASE_DIV)) sk_run <= sk_run + 1'b1;
      if (cs_o != cs_q)                 cs_run <= RW'(1);
      else if (cs_run < RW'(PHASE_DIV)) cs_run <= cs_run + 1'b1;
    end
  end

  AST_SETUP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> !sk_o && !di_o); // R3
  AST_SK_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_o != sk_q) |-> sk_run >= RW'(PHASE_DIV)); // R4
  AST_DI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_o && $past(sk_o)) |-> $stable(di_o)); // R5
  AST_SK_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o); // R5
  AST_TAIL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> !$past(sk_o)); // R10
  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o && !cs_q) |-> cs_run >= RW'(PHASE_DIV)); // R10
  AST_OWN_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> own_o); // R2
  AST_NO_ACK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_o |-> !ack_o); // R2
  AST_DONE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !own_o && !cs_o); // R12
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk #(.PHASE_DIV(PHASE_DIV)) i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .ack_o (ack_o),
  .done_o(done_o),
  .own_o (own_o),
  .cs_o  (cs_o),
  .sk_o  (sk_o),
  .di_o  (di_o)
);

// File: tb/test_mw_eeprom_ctrl.sv
module test_mw_eeprom_ctrl;
  localparam int P  = 3;
  localparam int T  = 300;
  localparam int BUSY = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [7:0]  addr_i = 8'd0;
  logic [15:0] wdata_i = 16'd0;
  logic        wide_i = 1'b1;
  logic        ack_o, done_o, own_o, cs_o, sk_o, di_o, do_i;
  logic [15:0] rdata_o;

  mw_eeprom_ctrl #(.PHASE_DIV(P), .WR_TIMEOUT(T)) i_mw_eeprom_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .op_i(op_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wide_addr_i(wide_i), .ack_o(ack_o), .rdata_o(rdata_o),
    .done_o(done_o), .own_o(own_o), .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o), .do_i(do_i)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [15:0] mem [256];
  int          cyc = 0;
  int          busy_until = 0;
  bit          hang = 0;
  int          m_aw = 8;
  int          bitcnt = 0;
  int          last_bits = 0;
  logic [31:0] sh = '0;
  bit          reading = 0;
  logic [15:0] rd_sh = '0;
  logic        do_r = 1'b1;
  bit          m_we = 0;
  logic [2:0]  opc = '0;

  always @(posedge clk) cyc <= cyc + 1;
  assign do_i = reading ? do_r : ((cyc < busy_until) ? 1'b0 : 1'b1);

  always @(posedge sk_o or negedge cs_o) begin
    if (!cs_o) begin
      if (bitcnt > 0) last_bits = bitcnt;
      bitcnt  = 0;
      reading = 0;
      opc     = '0;
    end else begin
      int mask;
      mask = (1 << m_aw) - 1;
      bitcnt++;
      if (reading) begin
        do_r  = rd_sh[15];
        rd_sh = rd_sh << 1;
      end else begin
        sh = {sh[30:0], di_o};
      end
      if (bitcnt == 3) opc = sh[2:0];
      if (opc == 3'b100 && bitcnt == 5) begin
        if (sh[4:0] == 5'b10011) m_we = 1;
        else if (sh[4:0] == 5'b10000) m_we = 0;
      end
      if (opc == 3'b110 && bitcnt == 3 + m_aw && !reading) begin
        rd_sh   = mem[8'(int'(sh) & mask)];
        reading = 1;
      end
      if (opc == 3'b101 && bitcnt == 3 + m_aw + 16) begin
        if (m_we) mem[8'((int'(sh) >> 16) & mask)] = sh[15:0];
        busy_until = hang ? 32'h7fffffff : cyc + BUSY;
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [1:0]  op;
    logic [15:0] rdata;
    int          bits;
    string       tag;
  } item_t;

  item_t       sb [$];
  logic [15:0] exp_mem [256];
  bit          exp_we = 0;
  int          done_cnt = 0;

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] a,
                         input logic [15:0] d, input bit wide, input string tag);
    item_t it;
    int    ea, aw, n;
    aw = wide ? 8 : 6;
    ea = wide ? int'(a) : int'(a & 8'h3F);
    it.op    = op;
    it.rdata = exp_mem[ea];
    it.bits  = (op >= 2) ? 11 : 3 + aw + 16;
    it.tag   = tag;
    if (op == 2'd1 && exp_we) exp_mem[ea] = d;
    if (op == 2'd2) exp_we = 1;
    if (op == 2'd3) exp_we = 0;
    sb.push_back(it);
    @(negedge clk);
    while (own_o) @(negedge clk);
    m_aw    = aw;
    req_i   = 1'b1;
    op_i    = op;
    addr_i  = a;
    wdata_i = d;
    wide_i  = wide;
    n       = done_cnt;
    #1;
    chk(ack_o == 1'b1, "R2", "ack on idle request", int'(ack_o), 1);
    @(negedge clk);
    req_i = 1'b0;
    while (done_cnt == n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done_o) begin
      item_t it;
      done_cnt++;
      if (sb.size() == 0) begin
        chk(0, "R12", "done without command", 1, 0);
      end else begin
        it = sb.pop_front();
        chk(last_bits == it.bits, it.tag, "clock edges in frame", last_bits, it.bits);
        if (it.op == 2'd0)
          chk(rdata_o == it.rdata, "R6", "read word", int'(rdata_o), int'(it.rdata));
        chk(own_o == 1'b0 && cs_o == 1'b0, "R12", "pins released at done",
            int'({own_o, cs_o}), 0);
      end
    end
  end

  // pin watch: frame start and clock level widths
  logic cs_prev = 1'b0;
  logic sk_prev = 1'b0;
  int   run = 0;
  int   min_run = 1000000;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_o && !cs_prev)
        chk(!sk_o && !di_o, "R3", "quiet lines at select", int'({sk_o, di_o}), 0);
      if (sk_o != sk_prev) begin
        if (cs_o && run < min_run) min_run = run;
        run = 1;
      end else begin
        run++;
      end
    end
    cs_prev = cs_o;
    sk_prev = sk_o;
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R12 watchdog expired actual=%0d expected=%0d", done_cnt, sb.size());
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int t0, dur;
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 16'hA000 + 16'(i);
      exp_mem[i] = 16'hA000 + 16'(i);
    end
    repeat (3) @(negedge clk);
    chk({cs_o, sk_o, di_o, own_o, done_o} == 5'b0, "R1", "outputs in reset",
        int'({cs_o, sk_o, di_o, own_o, done_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cs_o, sk_o, di_o, own_o, done_o, ack_o} == 6'b0, "R1", "outputs after reset",
        int'({cs_o, sk_o, di_o, own_o, done_o, ack_o}), 0);

    // writes are refused by the device until enabled
    run_cmd(2'd1, 8'h12, 16'h1234, 1'b1, "R7");
    run_cmd(2'd0, 8'h12, 16'h0, 1'b1, "R6");
    run_cmd(2'd2, 8'h00, 16'h0, 1'b1, "R8");
    chk(m_we == 1, "R8", "enable decoded", int'(m_we), 1);

    t0 = cyc;
    run_cmd(2'd1, 8'h12, 16'h1234, 1'b1, "R7");
    dur = cyc - t0;
    chk(dur < T, "R11", "ready ends write wait early", dur, T);
    run_cmd(2'd0, 8'h12, 16'h0, 1'b1, "R6");

    run_cmd(2'd1, 8'h80, 16'h8001, 1'b1, "R7");
    chk(mem[8'h80] == 16'h8001, "R5", "bit order of stored word", int'(mem[8'h80]), 'h8001);
    run_cmd(2'd0, 8'h80, 16'h0, 1'b1, "R6");
    run_cmd(2'd1, 8'h81, 16'h0000, 1'b1, "R7");
    run_cmd(2'd1, 8'h82, 16'hFFFF, 1'b1, "R7");
    run_cmd(2'd0, 8'h81, 16'h0, 1'b1, "R6");
    run_cmd(2'd0, 8'h82, 16'h0, 1'b1, "R6");

    // narrow address mode
    run_cmd(2'd1, 8'h3F, 16'h5A5A, 1'b0, "R9");
    chk(mem[8'h3F] == 16'h5A5A, "R9", "narrow write address", int'(mem[8'h3F]), 'h5A5A);
    run_cmd(2'd0, 8'h3F, 16'h0, 1'b0, "R9");
    run_cmd(2'd0, 8'h3F, 16'h0, 1'b1, "R9");
    run_cmd(2'd0, 8'hC5, 16'h0, 1'b0, "R9");

    // request while busy is ignored
    fork
      run_cmd(2'd0, 8'h80, 16'h0, 1'b1, "R6");
      begin
        repeat (20) @(negedge clk);
        req_i   = 1'b1;
        op_i    = 2'd1;
        addr_i  = 8'h83;
        wdata_i = 16'h0BAD;
        #1;
        chk(ack_o == 1'b0, "R2", "no ack while busy", int'(ack_o), 0);
        @(negedge clk);
        req_i = 1'b0;
      end
    join
    run_cmd(2'd0, 8'h83, 16'h0, 1'b1, "R2");

    // disable blocks writes
    run_cmd(2'd3, 8'h00, 16'h0, 1'b1, "R8");
    chk(m_we == 0, "R8", "disable decoded", int'(m_we), 0);
    run_cmd(2'd1, 8'h12, 16'hFFFF, 1'b1, "R7");
    run_cmd(2'd0, 8'h12, 16'h0, 1'b1, "R6");

    // device never ready: wait ends by time limit
    run_cmd(2'd2, 8'h00, 16'h0, 1'b1, "R8");
    hang = 1;
    t0 = cyc;
    run_cmd(2'd1, 8'h20, 16'hC3C3, 1'b1, "R11");
    dur = cyc - t0;
    hang = 0;
    busy_until = 0;
    chk(dur >= T && dur <= T + 2 * 27 * P + 6 * P + 10, "R11", "timeout wait length",
        dur, T);
    run_cmd(2'd0, 8'h20, 16'h0, 1'b1, "R6");

    chk(min_run >= P, "R4", "shortest clock level", min_run, P);
    chk(sb.size() == 0, "R12", "all commands completed", sb.size(), 0);
    // R10 is held by the bound checker; done pulses above prove release order
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule